// File: doc/BRIEF.md
# Eviction Skew Detector

This block watches the eviction stream of a randomized last-level cache. Each eviction arrives as a strobe together with the index of the set that lost a line. The block keeps an eviction histogram with one counter per set. When a programmable number of evictions has been seen, it closes the window and scans the histogram one entry per cycle. The scan gathers the sum, the sum of squares and the largest count.

From these three figures it tests whether the busiest set lies unusually far from the mean, measured in standard deviations, against a programmable integer threshold. The test uses integer arithmetic only. A set hammered by an eviction-set search stands out in this way, while ordinary traffic spreads evenly across the sets. When the test trips, the block emits a one-cycle pulse that the remap controller takes as a request for an extra remap.

Two histogram banks alternate. Evictions that arrive while one bank is being scanned go into the other bank. As the scanner reads each entry, it zeroes it, so the bank is empty by the time it becomes active again.

Top module: `evict_skew_detector`

## Requirements
- R1: After reset the output is low and both histograms are cleared by a sweep that lasts NUM_SETS cycles. Evictions offered during that sweep are dropped: they count neither toward a set nor toward the window.
- R2: A window closes only once the number of accepted evictions in it reaches `window_len` and no scan is in progress. Until then no decision is made and no pulse appears.
- R3: With N = NUM_SETS, S the sum of the counts, Q the sum of their squares, M the largest count and T the threshold, the pulse is raised exactly when (N*M - S)^2 > T^2 * (N*Q - S^2). The comparison is strict, so a perfectly even histogram never trips it.
- R4: Each closed window produces at most one pulse, exactly one cycle wide, within NUM_SETS + 8 cycles of the window closing.
- R5: Each per-set count saturates at 2^CNT_W - 1 and never wraps.
- R6: Evictions accepted while the previous window is being scanned go into the other bank and are counted in the next window; none is lost.
- R7: A scanned bank is left all-zero, so no count leaks into any later window that uses the same bank.
- R8: The threshold is live. The same histogram that trips with a small threshold gives no pulse with a large one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evict_valid | input | 1 | One eviction this cycle |
| evict_set | input | IDX_W | Set index of the eviction |
| window_len | input | WIN_W | Number of evictions that make up one observation window |
| threshold | input | THR_W | Integer deviation threshold, in standard deviations |
| attack_pulse | output | 1 | One-cycle request for an extra remap |

## Verification
The assertions take for granted that `window_len` and `threshold` are held steady from the start of a window until its decision has been made. They also assume that nothing depends on an eviction offered in the very cycle the window closes, because that eviction still lands in the closing bank.

The stimulus follows these rules. It sets both inputs before each window and leaves them alone until the result has been checked. After the last eviction of a window it idles for at least two cycles. It starts the next window's traffic only after that gap, even when that traffic deliberately overlaps a running scan.

// File: rtl/esd_pkg.sv
package esd_pkg;
  typedef enum logic [2:0] {
    SC_INIT,
    SC_IDLE,
    SC_GAP,
    SC_READ,
    SC_DRAIN,
    SC_DEV,
    SC_CMP
  } scan_state_t;
endpackage

// File: rtl/esd_bank_ram.sv
module esd_bank_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/esd_scanner.sv
module esd_scanner
  import esd_pkg::*;
#(
  parameter int NUM_SETS = 1024,
  parameter int CNT_W    = 8,
  parameter int THR_W    = 8,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_bank,
  input  logic [THR_W-1:0] threshold,
  input  logic [CNT_W-1:0] rdata,
  output logic             busy,
  output logic             clr_all,
  output logic             bank,
  output logic [IDX_W-1:0] raddr,
  output logic             we,
  output logic [IDX_W-1:0] waddr,
  output logic             attack_pulse
);
  localparam int SUM_W = CNT_W + IDX_W;
  localparam int SQ_W  = 2 * CNT_W + IDX_W;
  localparam int VAR_W = 2 * SUM_W;
  localparam int RHS_W = VAR_W + 2 * THR_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SETS - 1);

  scan_state_t      state;
  logic [IDX_W-1:0] addr, d_addr;
  logic             d_v;
  logic [SUM_W-1:0] sum_acc, dev_r;
  logic [SQ_W-1:0]  sq_acc;
  logic [CNT_W-1:0] max_acc;
  logic [VAR_W-1:0] var_r, lhs;
  logic [RHS_W-1:0] rhs;
  logic [IDX_W-1:0] addr_nxt;

  assign addr_nxt = (addr == LAST) ? '0 : addr + 1'b1;
  assign busy     = (state != SC_IDLE);
  assign clr_all  = (state == SC_INIT);
  assign raddr    = addr;
  assign we       = clr_all || d_v;
  assign waddr    = clr_all ? addr : d_addr;

  assign lhs = VAR_W'(dev_r) * VAR_W'(dev_r);
  assign rhs = RHS_W'(threshold) * RHS_W'(threshold) * RHS_W'(var_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SC_INIT;
      addr         <= '0;
      d_addr       <= '0;
      d_v          <= 1'b0;
      bank         <= 1'b0;
      sum_acc      <= '0;
      sq_acc       <= '0;
      max_acc      <= '0;
      dev_r        <= '0;
      var_r        <= '0;
      attack_pulse <= 1'b0;
    end else begin
      d_v          <= (state == SC_READ);
      d_addr       <= addr;
      attack_pulse <= 1'b0;
      if (d_v) begin
        sum_acc <= sum_acc + SUM_W'(rdata);
        sq_acc  <= sq_acc + SQ_W'(rdata) * SQ_W'(rdata);
        if (rdata > max_acc) max_acc <= rdata;
      end
      case (state)
        SC_INIT: begin
          addr <= addr_nxt;
          if (addr == LAST) state <= SC_IDLE;
        end
        SC_IDLE: begin
          if (start) begin
            bank    <= start_bank;
            sum_acc <= '0;
            sq_acc  <= '0;
            max_acc <= '0;
            state   <= SC_GAP;
          end
        end
        SC_GAP: begin
          addr  <= '0;
          state <= SC_READ;
        end
        SC_READ: begin
          addr <= addr_nxt;
          if (addr == LAST) state <= SC_DRAIN;
        end
        SC_DRAIN: state <= SC_DEV;
        SC_DEV: begin
          dev_r <= {max_acc, {IDX_W{1'b0}}} - sum_acc;
          var_r <= {sq_acc, {IDX_W{1'b0}}} - VAR_W'(sum_acc) * VAR_W'(sum_acc);
          state <= SC_CMP;
        end
        SC_CMP: begin
          attack_pulse <= (RHS_W'(lhs) > rhs);
          state        <= SC_IDLE;
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  // R4: the detect output never stays high for two cycles in a row
  p_pulse_once_r4: assert property (@(posedge clk) disable iff (rst)
    attack_pulse |=> !attack_pulse);

  // R3: the largest count is never below the mean once the totals are final
  p_max_ge_mean_r3: assert property (@(posedge clk) disable iff (rst)
    (state == SC_DEV) |-> ({max_acc, {IDX_W{1'b0}}} >= sum_acc));
endmodule

// File: rtl/evict_skew_detector.sv
module evict_skew_detector #(
  parameter int NUM_SETS = 1024,
  parameter int CNT_W    = 8,
  parameter int WIN_W    = 16,
  parameter int THR_W    = 8,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evict_valid,
  input  logic [IDX_W-1:0] evict_set,
  input  logic [WIN_W-1:0] window_len,
  input  logic [THR_W-1:0] threshold,
  output logic             attack_pulse
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [WIN_W-1:0] WMAX = {WIN_W{1'b1}};

  logic             act_bank;
  logic [WIN_W-1:0] win_cnt;
  logic             scan_busy, clr_all, sc_we, sc_bank;
  logic [IDX_W-1:0] sc_raddr, sc_waddr;
  logic [CNT_W-1:0] rd [2];
  logic [CNT_W-1:0] sc_rdata;
  logic             ev_ok, swap;

  // update pipeline: read in stage 0, modify and write in stage 1
  logic             u_v, u_bank;
  logic [IDX_W-1:0] u_idx;
  logic             f_v, f_bank;
  logic [IDX_W-1:0] f_idx;
  logic [CNT_W-1:0] f_data;
  logic [CNT_W-1:0] u_old, u_new;

  assign ev_ok = evict_valid && !clr_all;
  assign swap  = !scan_busy && (win_cnt >= window_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_bank <= 1'b0;
      win_cnt  <= '0;
    end else if (swap) begin
      act_bank <= ~act_bank;
      win_cnt  <= '0;
    end else if (ev_ok && win_cnt != WMAX) begin
      win_cnt <= win_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      u_v    <= 1'b0;
      u_bank <= 1'b0;
      u_idx  <= '0;
      f_v    <= 1'b0;
      f_bank <= 1'b0;
      f_idx  <= '0;
      f_data <= '0;
    end else begin
      u_v    <= ev_ok;
      u_bank <= act_bank;
      u_idx  <= evict_set;
      f_v    <= u_v;
      f_bank <= u_bank;
      f_idx  <= u_idx;
      f_data <= u_new;
    end
  end

  assign sc_rdata = rd[sc_bank];
  assign u_old = (f_v && f_bank == u_bank && f_idx == u_idx) ? f_data : rd[u_bank];
  assign u_new = (u_old == CMAX) ? CMAX : u_old + 1'b1;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic             upd_we, scn_we;
    logic [IDX_W-1:0] raddr_b, waddr_b;
    logic [CNT_W-1:0] wdata_b;

    assign upd_we  = u_v && (u_bank == 1'(b));
    assign scn_we  = sc_we && (clr_all || sc_bank == 1'(b));
    assign raddr_b = (act_bank == 1'(b)) ? evict_set : sc_raddr;
    assign waddr_b = upd_we ? u_idx : sc_waddr;
    assign wdata_b = upd_we ? u_new : '0;

    esd_bank_ram #(.DEPTH(NUM_SETS), .WIDTH(CNT_W)) u_ram (
      .clk   (clk),
      .we    (upd_we || scn_we),
      .waddr (waddr_b),
      .wdata (wdata_b),
      .raddr (raddr_b),
      .rdata (rd[b])
    );

    // R6: counting and scanning never compete for one bank's write port
    p_port_split_r6: assert property (@(posedge clk) disable iff (rst)
      !(upd_we && scn_we));
  end

  esd_scanner #(.NUM_SETS(NUM_SETS), .CNT_W(CNT_W), .THR_W(THR_W)) u_scan (
    .clk          (clk),
    .rst          (rst),
    .start        (swap),
    .start_bank   (act_bank),
    .threshold    (threshold),
    .rdata        (sc_rdata),
    .busy         (scan_busy),
    .clr_all      (clr_all),
    .bank         (sc_bank),
    .raddr        (sc_raddr),
    .we           (sc_we),
    .waddr        (sc_waddr),
    .attack_pulse (attack_pulse)
  );

  // R2: a scan only begins after the window has filled
  p_window_full_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(scan_busy) |-> ($past(win_cnt) >= $past(window_len)));

  // R5: an incremented count is never written back as zero
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    u_v |-> (u_new != '0));
endmodule

// File: tb/evict_skew_detector_test.sv
module evict_skew_detector_test;
  localparam int N     = 1024;
  localparam int CNT_W = 8;
  localparam int WIN_W = 16;
  localparam int THR_W = 8;
  localparam int IDX_W = $clog2(N);
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             evict_valid = 1'b0;
  logic [IDX_W-1:0] evict_set = '0;
  logic [WIN_W-1:0] window_len = 16'd1024;
  logic [THR_W-1:0] threshold = 8'd4;
  logic             attack_pulse;

  int checks = 0;
  int fails  = 0;
  int pulse_seen = 0;
  int model [N];

  always #5 clk = ~clk;

  evict_skew_detector #(.NUM_SETS(N), .CNT_W(CNT_W), .WIN_W(WIN_W), .THR_W(THR_W)) uut (
    .clk          (clk),
    .rst          (rst),
    .evict_valid  (evict_valid),
    .evict_set    (evict_set),
    .window_len   (window_len),
    .threshold    (threshold),
    .attack_pulse (attack_pulse)
  );

  always @(negedge clk) if (!rst && attack_pulse) pulse_seen++;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < N; i++) model[i] = 0;
    pulse_seen = 0;
  endtask

  task automatic send(input int idx);
    @(negedge clk);
    evict_valid = 1'b1;
    evict_set   = IDX_W'(idx);
    if (model[idx] < CMAX) model[idx]++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evict_valid = 1'b0;
    end
  endtask

  function automatic int decide(input int t);
    longint s = 0, q = 0, m = 0, dev, vr;
    for (int i = 0; i < N; i++) begin
      s += model[i];
      q += longint'(model[i]) * model[i];
      if (model[i] > m) m = model[i];
    end
    dev = longint'(N) * m - s;
    vr  = longint'(N) * q - s * s;
    return (dev * dev > longint'(t) * t * vr) ? 1 : 0;
  endfunction

  function automatic int max_trip_t();
    for (int t = 255; t >= 0; t--) if (decide(t) != 0) return t;
    return 0;
  endfunction

  task automatic send_uniform();
    for (int i = 0; i < N; i++) send(i);
  endtask

  // R1: output low in reset, evictions during the clear sweep are dropped
  task automatic t_reset();
    rst = 1'b1;
    idle(5);
    check("R1 pulse low in reset", int'(attack_pulse), 0);
    rst = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      evict_valid = 1'b1;
      evict_set   = IDX_W'(3);
    end
    idle(N + 10);
    clear_model();
    threshold  = 8'd4;
    window_len = 16'(N);
    send_uniform();
    idle(N + 30);
    check("R1 sweep-time evictions ignored", pulse_seen, decide(4));
  endtask

  // R2, R4: no decision before the window fills; one single-cycle pulse after
  task automatic t_window();
    clear_model();
    threshold  = 8'd4;
    window_len = 16'd512;
    for (int i = 0; i < 511; i++) send(9);
    idle(N + 30);
    check("R2 no pulse before window fills", pulse_seen, 0);
    send(9);
    idle(N + 30);
    check("R4 one pulse one cycle wide", pulse_seen, decide(4));
  endtask

  task automatic skew_pattern();
    for (int i = 0; i < 256; i++) send(5);
    for (int i = 600; i < 856; i++) send(i);
  endtask

  // R3, R8: strict comparison at the boundary and a live threshold
  task automatic t_threshold(input int t, input string req);
    clear_model();
    threshold  = THR_W'(t);
    window_len = 16'd512;
    skew_pattern();
    idle(N + 30);
    check(req, pulse_seen, decide(t));
  endtask

  // R5: a count driven past its maximum stays at the maximum
  task automatic t_saturate();
    clear_model();
    threshold  = 8'd18;
    window_len = 16'd5420;
    for (int r = 0; r < 20; r++)
      for (int i = 0; i < 256; i++) send(i);
    for (int i = 0; i < 300; i++) send(700);
    idle(N + 30);
    check("R5 saturated count decides", pulse_seen, decide(18));
  endtask

  task automatic overlap_pattern();
    for (int i = 0; i < 256; i++) send(i);
    for (int i = 0; i < 7; i++) send(11);
  endtask

  // R6: events sent during a scan land in the next window intact
  task automatic t_overlap();
    int t2, exp1, exp2;
    clear_model();
    overlap_pattern();
    idle(1);
    t2   = max_trip_t();
    exp2 = decide(t2);
    idle(N + 30);
    clear_model();
    threshold  = THR_W'(t2);
    window_len = 16'd64;
    for (int i = 0; i < 64; i++) send(40);
    exp1 = decide(t2);
    idle(1);
    window_len = 16'd263;
    idle(1);
    for (int i = 0; i < N; i++) model[i] = 0;
    overlap_pattern();
    idle(3 * N);
    check("R6 both windows decide", pulse_seen, exp1 + exp2);
  endtask

  // R7: a scanned bank returns empty
  task automatic t_clear();
    clear_model();
    threshold  = 8'd4;
    window_len = 16'd512;
    for (int i = 0; i < 512; i++) send(9);
    idle(N + 30);
    check("R7 attack window trips", pulse_seen, decide(4));
    clear_model();
    window_len = 16'(N);
    send_uniform();
    idle(N + 30);
    check("R7 even window after attack", pulse_seen, 0);
    clear_model();
    send_uniform();
    idle(N + 30);
    check("R7 reused bank is clean", pulse_seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_window();
    t_threshold(255, "R8 large threshold no pulse");
    t_threshold(32, "R3 strict boundary below");
    t_threshold(31, "R3 strict boundary above");
    t_threshold(4, "R8 small threshold trips");
    t_saturate();
    clear_model();
    threshold  = 8'd4;
    window_len = 16'(N);
    send_uniform();
    idle(N + 30);
    check("R3 even histogram no pulse", pulse_seen, 0);
    t_overlap();
    t_clear();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule